// File: doc/BRIEF.md
# Two-Level Page Walker with 36-Bit Large Pages

This block turns a 32-bit linear address into a 36-bit physical address by walking a two-level structure in memory: a directory of 1024 entries, and page tables of 1024 entries each. A directory entry either maps a 4 MB page directly, with four extra physical address bits held inside the entry, or points to a page table whose entry maps a 4 KB page below 4 GB. One request is taken at a time over a valid/ready handshake carrying the linear address and a write flag. The walker reads entries over a 32-bit request/acknowledge memory port.

On a successful walk the walker sets the accessed flag in the entries it used and sets the dirty flag in the final entry on a write. Every entry that changed is written back before the response. A response is a one-cycle pulse with the physical address and a 2-bit status. When paging is off, the linear address comes back unchanged, without any memory traffic. The control bits and the directory base are sampled when a request is accepted, so they may change while a walk is running.

Top module: `pgw_walker`

## Requirements
- R1: With `paging_en` low at acceptance, `rsp_valid` pulses in the cycle after acceptance with `rsp_paddr` equal to the linear address zero-extended to 36 bits and status 0 (ok), and no memory request is made.
- R2: The directory entry is read at {`dir_base`[31:12], linear[31:22], 2'b00}, and a page-table entry at {directory entry[31:12], linear[21:12], 2'b00}.
- R3: When `pse_en`=1, `pae_en`=0 and directory entry bit 7 = 1, the entry maps a 4 MB page: physical address = {entry[16:13], entry[31:22], linear[21:0]}, and no table is read.
- R4: Otherwise a present directory entry leads to a table read, and physical address = {4'b0, table entry[31:12], linear[11:0]}.
- R5: Status codes are 0 ok, 1 not-present, 2 reserved-bit. An entry with bit 0 clear gives status 1 whatever its other bits hold, and the walk stops there with no write. Every fault response carries physical address 0.
- R6: With `pse_en`=1, a nonzero reserved bit gives status 2. The reserved bits are bits 21:17 of a 4 MB directory entry, bit 6 of a directory entry that points to a table, and bit 7 of a table entry. With `pse_en`=0 these bits are ignored.
- R7: On success, bit 5 (accessed) is set in the final entry and, for a 4 KB walk, in the directory entry. Bit 6 (dirty) is set in the final entry when the request is a write. All other entry bits are kept. Nothing is written on a fault.
- R8: An entry is written back only if its value changed, the directory entry before the table entry, and every write is acknowledged before `rsp_valid`.
- R9: `rsp_valid` is a single-cycle pulse. `req_ready` is low from the cycle after acceptance through the response cycle and high otherwise, reset included.
- R10: Once `mem_req` is raised, it and `mem_addr`, `mem_we`, `mem_wdata` hold steady until a cycle with `mem_ack` high.
- R11: Changes to `paging_en`, `pae_en`, `pse_en` and `dir_base` after acceptance do not affect the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Request is a write access |
| paging_en | input | 1 | Translation enable |
| pae_en | input | 1 | Wide-entry mode; when set, large pages are unavailable |
| pse_en | input | 1 | Large-page and reserved-bit checking enable |
| dir_base | input | 32 | Directory base; bits 31:12 used |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 36 | Physical address (0 on fault) |
| rsp_status | output | 2 | 0 ok, 1 not-present, 2 reserved-bit |

## Verification
The bench sweeps every combination of paging, wide-entry and large-page enables, the directory page-size bit, present and reserved bits at both levels, the access type, and whether the flags were already set. This separates the 4 MB and 4 KB paths, fault priority and the cases where a write-back is skipped. Each case uses a distinct directory index, table slot, frame and base. Checking both the exact access sequence and the stored entries shows whether addresses are built from the right fields. Memory latency is varied, and the controls are inverted right after acceptance, to expose any use of the live control inputs.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  // Response status codes.
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_NOTPRES = 2'd1,
    ST_RSVD    = 2'd2
  } xlat_status_e;

  // Walk sequencer states.
  typedef enum logic [2:0] {
    W_IDLE,
    W_DIR_RD,
    W_TBL_RD,
    W_DIR_WR,
    W_FIN_WR
  } walk_state_e;

  // Entry bit positions used by the walk.
  localparam int PRES_BIT  = 0;
  localparam int ACC_BIT   = 5;
  localparam int DIRTY_BIT = 6;
  localparam int PSIZE_BIT = 7;
  localparam int RSV_LO    = 17;
  localparam int RSV_HI    = 21;
  localparam int HI_PA_LO  = 13;

  // Control snapshot taken at acceptance.
  typedef struct packed {
    logic pse;
    logic pae;
  } ctl_t;
endpackage

// File: rtl/pgw_entry_eval.sv
`timescale 1ns/1ps
module pgw_entry_eval
  import pgw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent,
  input  logic             is_dir,
  input  logic             large_ok,
  input  logic             chk_rsvd,
  input  logic             is_write,
  output logic             present,
  output logic             is_large,
  output logic             rsvd_hit,
  output logic [ENT_W-1:0] upd
);
  logic rsv_raw;

  always_comb begin
    present  = ent[PRES_BIT];
    is_large = is_dir & large_ok & ent[PSIZE_BIT];
    if (is_large)    rsv_raw = |ent[RSV_HI:RSV_LO];
    else if (is_dir) rsv_raw = ent[DIRTY_BIT];
    else             rsv_raw = ent[PSIZE_BIT];
    rsvd_hit = rsv_raw & chk_rsvd;
    upd = ent;
    upd[ACC_BIT] = 1'b1;
    if ((is_large | ~is_dir) & is_write) upd[DIRTY_BIT] = 1'b1;
  end
endmodule

// File: rtl/pgw_addr_gen.sv
`timescale 1ns/1ps
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int LIN_W  = 32,
  parameter int PA_W   = 36,
  parameter int PG_SH  = 12,
  parameter int DIR_SH = 22
) (
  input  logic [LIN_W-PG_SH-1:0] base_frame,
  input  logic [LIN_W-1:0]       lin,
  input  logic [LIN_W-PG_SH-1:0] ent_frame,
  output logic [LIN_W-1:0]       dir_addr,
  output logic [LIN_W-1:0]       tbl_addr,
  output logic [PA_W-1:0]        pa_large,
  output logic [PA_W-1:0]        pa_small
);
  localparam int EXT_W   = PA_W - LIN_W;
  localparam int FR_HILO = HI_PA_LO - PG_SH;
  localparam int FR_HIHI = FR_HILO + EXT_W - 1;
  localparam int FR_LRG  = DIR_SH - PG_SH;

  always_comb begin
    dir_addr = {base_frame, lin[LIN_W-1:DIR_SH], 2'b00};
    tbl_addr = {ent_frame, lin[DIR_SH-1:PG_SH], 2'b00};
    pa_large = {ent_frame[FR_HIHI:FR_HILO], ent_frame[LIN_W-PG_SH-1:FR_LRG],
                lin[DIR_SH-1:0]};
    pa_small = {{EXT_W{1'b0}}, ent_frame, lin[PG_SH-1:0]};
  end
endmodule

// File: rtl/pgw_walker.sv
`timescale 1ns/1ps
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int LIN_W = 32,
  parameter int PA_W  = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LIN_W-1:0] req_lin,
  input  logic             req_write,
  input  logic             paging_en,
  input  logic             pae_en,
  input  logic             pse_en,
  input  logic [LIN_W-1:0] dir_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [LIN_W-1:0] mem_addr,
  output logic [LIN_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [LIN_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_status
);
  localparam int PG_SH = 12;
  localparam int FR_W  = LIN_W - PG_SH;
  localparam int EXT_W = PA_W - LIN_W;

  walk_state_e state, nxt;
  ctl_t              ctl_q;
  logic [LIN_W-1:0]  lin_q, dir_addr_q, tbl_addr_q, pde_upd_q, pte_upd_q;
  logic              wr_q, pde_chg_q, pte_chg_q;
  logic [PA_W-1:0]   pa_q;

  logic              e_present, e_large, e_rsvd;
  logic [LIN_W-1:0]  e_upd, g_dir_addr, g_tbl_addr;
  logic [PA_W-1:0]   g_pa_large, g_pa_small;
  logic [LIN_W-1:0]  lin_sel;

  logic              cmd, cmd_we, fin;
  logic [LIN_W-1:0]  cmd_addr, cmd_wdata;
  xlat_status_e      fin_st;
  logic [PA_W-1:0]   fin_pa;

  logic unused_base;
  assign unused_base = ^dir_base[PG_SH-1:0];

  assign lin_sel   = (state == W_IDLE) ? req_lin : lin_q;
  assign req_ready = (state == W_IDLE) && !rsp_valid;

  pgw_entry_eval #(.ENT_W(LIN_W)) eval_i (
    .ent      (mem_rdata),
    .is_dir   (state == W_DIR_RD),
    .large_ok (ctl_q.pse & ~ctl_q.pae),
    .chk_rsvd (ctl_q.pse),
    .is_write (wr_q),
    .present  (e_present),
    .is_large (e_large),
    .rsvd_hit (e_rsvd),
    .upd      (e_upd)
  );

  pgw_addr_gen #(.LIN_W(LIN_W), .PA_W(PA_W), .PG_SH(PG_SH)) agen_i (
    .base_frame (dir_base[LIN_W-1:PG_SH]),
    .lin        (lin_sel),
    .ent_frame  (mem_rdata[LIN_W-1:PG_SH]),
    .dir_addr   (g_dir_addr),
    .tbl_addr   (g_tbl_addr),
    .pa_large   (g_pa_large),
    .pa_small   (g_pa_small)
  );

  // Next-step decision for the walk.
  always_comb begin
    nxt       = state;
    cmd       = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = mem_addr;
    cmd_wdata = mem_wdata;
    fin       = 1'b0;
    fin_st    = ST_OK;
    fin_pa    = '0;
    case (state)
      W_IDLE: begin
        if (req_ready && req_valid) begin
          if (!paging_en) begin
            fin    = 1'b1;
            fin_pa = {{EXT_W{1'b0}}, req_lin};
          end else begin
            cmd      = 1'b1;
            cmd_addr = g_dir_addr;
            nxt      = W_DIR_RD;
          end
        end
      end
      W_DIR_RD: begin
        if (mem_ack) begin
          if (!e_present) begin
            fin = 1'b1; fin_st = ST_NOTPRES;
          end else if (e_rsvd) begin
            fin = 1'b1; fin_st = ST_RSVD;
          end else if (e_large) begin
            if (e_upd != mem_rdata) begin
              cmd = 1'b1; cmd_we = 1'b1; cmd_addr = dir_addr_q; cmd_wdata = e_upd;
              nxt = W_FIN_WR;
            end else begin
              fin = 1'b1; fin_pa = g_pa_large;
            end
          end else begin
            cmd = 1'b1; cmd_addr = g_tbl_addr;
            nxt = W_TBL_RD;
          end
        end
      end
      W_TBL_RD: begin
        if (mem_ack) begin
          if (!e_present) begin
            fin = 1'b1; fin_st = ST_NOTPRES;
          end else if (e_rsvd) begin
            fin = 1'b1; fin_st = ST_RSVD;
          end else if (pde_chg_q) begin
            cmd = 1'b1; cmd_we = 1'b1; cmd_addr = dir_addr_q; cmd_wdata = pde_upd_q;
            nxt = W_DIR_WR;
          end else if (e_upd != mem_rdata) begin
            cmd = 1'b1; cmd_we = 1'b1; cmd_addr = tbl_addr_q; cmd_wdata = e_upd;
            nxt = W_FIN_WR;
          end else begin
            fin = 1'b1; fin_pa = g_pa_small;
          end
        end
      end
      W_DIR_WR: begin
        if (mem_ack) begin
          if (pte_chg_q) begin
            cmd = 1'b1; cmd_we = 1'b1; cmd_addr = tbl_addr_q; cmd_wdata = pte_upd_q;
            nxt = W_FIN_WR;
          end else begin
            fin = 1'b1; fin_pa = pa_q;
          end
        end
      end
      W_FIN_WR: begin
        if (mem_ack) begin
          fin = 1'b1; fin_pa = pa_q;
        end
      end
      default: nxt = W_IDLE;
    endcase
    if (fin) nxt = W_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      ctl_q      <= '0;
      lin_q      <= '0;
      wr_q       <= 1'b0;
      dir_addr_q <= '0;
      tbl_addr_q <= '0;
      pde_upd_q  <= '0;
      pte_upd_q  <= '0;
      pde_chg_q  <= 1'b0;
      pte_chg_q  <= 1'b0;
      pa_q       <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_status <= ST_OK;
    end else begin
      state     <= nxt;
      rsp_valid <= fin;
      if (fin) begin
        rsp_paddr  <= fin_pa;
        rsp_status <= fin_st;
      end
      mem_req <= cmd | (mem_req & ~mem_ack);
      if (cmd) begin
        mem_we    <= cmd_we;
        mem_addr  <= cmd_addr;
        mem_wdata <= cmd_wdata;
      end
      if (state == W_IDLE && req_ready && req_valid) begin
        lin_q      <= req_lin;
        wr_q       <= req_write;
        ctl_q.pse  <= pse_en;
        ctl_q.pae  <= pae_en;
        dir_addr_q <= g_dir_addr;
      end
      if (state == W_DIR_RD && mem_ack) begin
        pde_upd_q  <= e_upd;
        pde_chg_q  <= (e_upd != mem_rdata);
        tbl_addr_q <= g_tbl_addr;
        pa_q       <= g_pa_large;
      end
      if (state == W_TBL_RD && mem_ack) begin
        pte_upd_q <= e_upd;
        pte_chg_q <= (e_upd != mem_rdata);
        pa_q      <= g_pa_small;
      end
    end
  end
endmodule

// File: rtl/pgw_checker.sv
`timescale 1ns/1ps
module pgw_checker #(
  parameter int LIN_W = 32,
  parameter int PA_W  = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LIN_W-1:0] req_lin,
  input logic             paging_en,
  input logic             mem_req,
  input logic             mem_we,
  input logic [LIN_W-1:0] mem_addr,
  input logic [LIN_W-1:0] mem_wdata,
  input logic             mem_ack,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_status
);
  localparam int EXT_W = PA_W - LIN_W;

  p_direct_map_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_en) |=>
      (rsp_valid && rsp_status == 2'd0 && rsp_paddr == {{EXT_W{1'b0}}, $past(req_lin)}));

  p_direct_nomem_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_en) |=> !mem_req);

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

  p_status_code_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'd3));

  p_wb_done_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && paging_en) |=> !req_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind pgw_walker pgw_checker #(.LIN_W(LIN_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_lin(req_lin), .paging_en(paging_en), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status)
);

// File: tb/pgw_walker_tb_top.sv
`timescale 1ns/1ps
module pgw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0;
  logic        paging_en = 1'b0;
  logic        pae_en = 1'b0;
  logic        pse_en = 1'b0;
  logic [31:0] dir_base = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [35:0] rsp_paddr;
  logic [1:0]  rsp_status;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pgw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_write(req_write), .paging_en(paging_en),
    .pae_en(pae_en), .pse_en(pse_en), .dir_base(dir_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status)
  );

  // Memory model: 4096 words, variable acknowledge latency, access log.
  logic [31:0] mem [0:4095];
  int          lat = 0;
  int          wcnt = 0;
  logic        pre_we = 1'b0;
  logic [31:0] pre_addr = '0;
  logic [31:0] pre_data = '0;
  int          acc_n = 0;
  logic [31:0] acc_addr [0:7];
  logic        acc_we [0:7];
  logic [31:0] acc_data [0:7];

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pre_we) mem[pre_addr[13:2]] <= pre_data;
    if (rst) wcnt <= 0;
    else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        wcnt    <= 0;
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[13:2]];
        acc_addr[acc_n % 8] <= mem_addr;
        acc_we[acc_n % 8]   <= mem_we;
        acc_data[acc_n % 8] <= mem_wdata;
        acc_n <= acc_n + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // R10 monitor: request fields must not move while waiting for acknowledge.
  int   hold_err = 0;
  logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;
  always @(negedge clk) begin
    if (!rst && p_req && !p_ack &&
        (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wdata))
      hold_err <= hold_err + 1;
    p_req <= mem_req; p_ack <= mem_ack; p_addr <= mem_addr;
    p_we <= mem_we; p_wdata <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  localparam logic [31:0] F_A  = 32'h20;
  localparam logic [31:0] F_D  = 32'h40;
  localparam logic [31:0] F_PS = 32'h80;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R9 reset rsp_valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R10 reset mem_req", mem_req, 0);

    for (int k = 0; k < 1024; k++) begin
      logic pg, pse, pae, ps, dp, drs, tp, trs, wr, pre;
      logic [31:0] lin, base, pde, pte, daddr, taddr, nd, nt, memd, memt;
      logic [31:0] ea [0:3];
      logic        ew [0:3];
      logic [31:0] ed [0:3];
      int          en, n0, w, busy_bad;
      logic [1:0]  est;
      logic [35:0] epa;
      logic        big, rsv;
      pg = k[0]; pse = k[1]; pae = k[2]; ps = k[3]; dp = k[4];
      drs = k[5]; tp = k[6]; trs = k[7]; wr = k[8]; pre = k[9];
      lat = k % 3;
      lin  = {k[9:0], 10'((k * 37 + 11) % 1024), 12'((k * 91) % 4096)};
      base = {18'((k * 29) % 262144), 2'b00, 12'(k * 7)};
      if (ps) begin
        pde = {10'((k * 613 + 5) % 1024), 5'b0, 4'(k / 16), 1'b1, 12'h000} | F_PS;
        if (pre) pde = pde | F_A | F_D;
        if (drs) pde = pde | (32'h1 << (17 + k % 5));
      end else begin
        pde = {20'(((k * 977) % 1048576) | 1), 12'h000};
        if (pre) pde = pde | F_A;
        if (drs) pde = pde | F_D;
      end
      pde = pde | {31'h0, dp} | 32'(k % 4) << 1;
      pte = {20'((k * 40503 + 77) % 1048576), 12'h000} | {31'h0, tp} | (32'(k % 8) << 9);
      if (pre) pte = pte | F_A | F_D;
      if (trs) pte = pte | F_PS;
      daddr = {base[31:12], lin[31:22], 2'b00};
      taddr = {pde[31:12], lin[21:12], 2'b00};

      // Expected behaviour from the requirements.
      en = 0; est = 2'd0; epa = '0; nd = pde; nt = pte;
      big = 1'b0;
      if (!pg) begin
        epa = {4'h0, lin};
      end else begin
        ea[0] = daddr; ew[0] = 1'b0; ed[0] = '0; en = 1;
        big = pse && !pae && pde[7];
        rsv = pse && (big ? (pde[21:17] != 0) : pde[6]);
        if (!dp) est = 2'd1;
        else if (rsv) est = 2'd2;
        else if (big) begin
          nd  = pde | F_A | (wr ? F_D : 32'h0);
          epa = {pde[16:13], pde[31:22], lin[21:0]};
          if (nd != pde) begin ea[en] = daddr; ew[en] = 1'b1; ed[en] = nd; en++; end
        end else begin
          ea[1] = taddr; ew[1] = 1'b0; ed[1] = '0; en = 2;
          if (!tp) est = 2'd1;
          else if (pse && pte[7]) est = 2'd2;
          else begin
            nd  = pde | F_A;
            nt  = pte | F_A | (wr ? F_D : 32'h0);
            epa = {4'h0, pte[31:12], lin[11:0]};
            if (nd != pde) begin ea[en] = daddr; ew[en] = 1'b1; ed[en] = nd; en++; end
            if (nt != pte) begin ea[en] = taddr; ew[en] = 1'b1; ed[en] = nt; en++; end
          end
        end
      end

      preload(daddr, pde);
      preload(taddr, pte);
      @(negedge clk);
      paging_en = pg; pse_en = pse; pae_en = pae; dir_base = base;
      req_lin = lin; req_write = wr; req_valid = 1'b1;
      n0 = acc_n;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      // R11: disturb every control input once the request is taken.
      paging_en = ~pg; pse_en = ~pse; pae_en = ~pae; dir_base = ~base;
      w = 0; busy_bad = 0;
      while (!rsp_valid && w < 300) begin
        if (req_ready) busy_bad++;
        @(negedge clk);
        w++;
      end
      chk(rsp_valid == 1'b1, "R9 response arrives", rsp_valid, 1);
      chk(busy_bad == 0, "R9 ready low while busy", busy_bad, 0);
      chk(rsp_status == est, est == 2'd2 ? "R6 reserved status" :
                             est == 2'd1 ? "R5 not-present status" : "R11 ok status",
          rsp_status, est);
      chk(rsp_paddr == epa, !pg ? "R1 direct paddr" : big ? "R3 large paddr" :
                            est != 0 ? "R5 fault paddr" : "R4 small paddr",
          rsp_paddr, epa);
      chk(acc_n - n0 == en, "R8 R11 access count", acc_n - n0, en);
      for (int j = 0; j < 4; j++) begin
        if (j < en && j < acc_n - n0) begin
          chk(acc_addr[(n0 + j) % 8] == ea[j] && acc_we[(n0 + j) % 8] == ew[j],
              ew[j] ? "R8 write-back order" : "R2 read address",
              {acc_we[(n0 + j) % 8], acc_addr[(n0 + j) % 8]}, {ew[j], ea[j]});
          if (ew[j])
            chk(acc_data[(n0 + j) % 8] == ed[j], "R7 write-back value",
                acc_data[(n0 + j) % 8], ed[j]);
        end
      end
      memd = mem[daddr[13:2]];
      memt = mem[taddr[13:2]];
      chk(memd == nd, "R7 directory entry flags", memd, nd);
      chk(memt == nt, "R7 table entry flags", memt, nt);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 single pulse then ready",
          {rsp_valid, req_ready}, 2'b01);
    end
    chk(hold_err == 0, "R10 request held until acknowledge", hold_err, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule